// File: doc/BRIEF.md
# Smart Card Activation and Answer-to-Reset Sequencer

This block is the session controller for the card side of a contact smart card interface. It watches three line levels coming from the reader side: supply present, card clock running, and the reset line. From these it steps the card through activation. Supply must come first, then clock, then reset release. After a guard interval counted in card clock enables, it plays a stored answer-to-reset (ATR) byte sequence out over a byte-wide valid/ready transmit interface. When the last byte has been accepted, it hands over to the command phase.

During the command phase, received bytes are passed on to a command layer. That layer reports the end of a protocol-parameter exchange or a command through `phase_done`. During a parameter exchange it may also write new Fi, Di and WI values. Every reset release restores these parameters to their initial values. Before a session starts, the stored ATR can be rewritten through a small load port.

States and transitions, with the 3-bit `phase` encoding:
- NOPWR (0): no supply. A supply rise moves to NOCLK.
- NOCLK (1): waiting for the clock. A clock rise moves to INRST.
- INRST (2): waiting for reset release.
- GUARD (3): counting the guard delay. On expiry it moves to ATR.
- ATR (4): sending the ATR. After the last byte is accepted it moves to IDLE.
- PPS (5): parameter exchange. `phase_done` returns to IDLE.
- IDLE (6): waiting for a command. A received 0xFF moves to PPS and any other byte moves to CMD.
- CMD (7): inside a command. `phase_done` returns to IDLE.

Two transitions apply from every state. Loss of supply goes to NOPWR. A valid reset release goes to GUARD.

Top module: `card_activation_ctrl`

## Requirements
- R1: After block reset, `phase` is 0, `tx_valid`, `tx_en`, `rx_en` and `ld_err` are 0, and the parameter outputs read fi=1, di=1, wi=10, wtime=9600.
- R2: While `sup_on` is low, the next cycle shows `phase`=0 and `tx_valid`=0, whatever the state was (an ATR in progress is abandoned).
- R3: A rising `sup_on` moves from NOPWR to NOCLK. A rising `cclk_on` moves NOCLK to INRST. A rising `cclk_on` in any other state leaves `phase` unchanged.
- R4: A reset release moves to GUARD from any state. A reset release is `rst_line` going from 1 (asserted) to 0. It counts only if `sup_on` and `cclk_on` are both high, and is ignored otherwise.
- R5: In GUARD, exactly GUARD_CLKS (default 400) clock edges with `cclk_en` high pass before `tx_valid` first rises. Edges with `cclk_en` low are not counted.
- R6: In ATR, bytes are offered in stored order from index 0. A byte is held stable while `tx_ready` is low and advances once per cycle with `tx_valid` and `tx_ready` both high.
- R7: In GUARD and ATR, `tx_en`=1 and `rx_en`=0. In NOPWR, NOCLK and INRST both are 0. In PPS, IDLE and CMD, `rx_en`=1 and `tx_en`=0. After the last ATR byte is accepted, the next cycle shows `phase`=6.
- R8: After block reset, the stored ATR is the four bytes 3B 02 14 50.
- R9: `ld_wr` writes `ld_data` at `ld_addr` (0..32). `ld_commit` sets the ATR length to `ld_len` for the next session. A length of 0 or above 33 is rejected: `ld_err` is high for exactly one cycle and the previous length stays in force.
- R10: Received bytes are dropped in every state before IDLE: `rx_fwd_valid` stays 0 and `phase` is unchanged. In PPS, IDLE and CMD, `rx_fwd_valid`/`rx_fwd_data` mirror `rx_valid`/`rx_data`. In IDLE, 0xFF enters PPS and any other byte enters CMD. `phase_done` returns PPS or CMD to IDLE.
- R11: `par_wr` in PPS loads fi, di and wi from `par_fi`/`par_di`/`par_wi` and sets wtime to wi×960. Outside PPS, `par_wr` has no effect.
- R12: Every reset release restores fi=1, di=1, wi=10 and wtime=9600, visible from the cycle after the release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low block reset |
| sup_on | input | 1 | Card supply present |
| cclk_on | input | 1 | Card clock present |
| rst_line | input | 1 | Card reset line level, 1 = asserted |
| cclk_en | input | 1 | One pulse per card clock, used by the guard delay |
| tx_valid | output | 1 | ATR byte offered |
| tx_data | output | 8 | ATR byte |
| tx_ready | input | 1 | Transmitter accepts the byte |
| tx_en | output | 1 | Transmitter enable |
| rx_en | output | 1 | Receiver enable |
| rx_valid | input | 1 | Received byte strobe |
| rx_data | input | 8 | Received byte |
| rx_fwd_valid | output | 1 | Received byte passed to the command layer |
| rx_fwd_data | output | 8 | Forwarded byte |
| phase_done | input | 1 | Command layer ends a PPS or command phase |
| par_wr | input | 1 | Parameter write strobe |
| par_fi | input | 4 | New clock-rate index |
| par_di | input | 4 | New baud-rate index |
| par_wi | input | 8 | New waiting integer |
| fi | output | 4 | Current clock-rate index |
| di | output | 4 | Current baud-rate index |
| wi | output | 8 | Current waiting integer |
| wtime | output | WT_W (18) | Current waiting time in ETUs |
| ld_wr | input | 1 | ATR byte write strobe |
| ld_addr | input | AW (6) | ATR byte index |
| ld_data | input | 8 | ATR byte value |
| ld_commit | input | 1 | Commit ATR length |
| ld_len | input | LW (6) | ATR length to commit |
| ld_err | output | 1 | One-cycle pulse on a rejected length |
| phase | output | 3 | Current state encoding |

## Verification
The state register is visible on `phase`, and it also drives the enables directly. A wrong state therefore shows up the cycle after the faulty transition, either as a mismatched `phase` or as `tx_en`/`rx_en` levels that do not fit the stimulus. Faults in the guard counter or the playback index appear later: as a first-byte time that is off by some number of enables, or as a byte order or count that differs from what the scoreboard expects, caught at the first bad handshake. Parameter faults are visible on the parameter outputs one cycle after the write or reset release that should have set them.

// File: rtl/card_act_pkg.sv
package card_act_pkg;

    typedef enum logic [2:0] {
        PH_NOPWR = 3'd0,
        PH_NOCLK = 3'd1,
        PH_INRST = 3'd2,
        PH_GUARD = 3'd3,
        PH_ATR   = 3'd4,
        PH_PPS   = 3'd5,
        PH_IDLE  = 3'd6,
        PH_CMD   = 3'd7
    } phase_t;

    localparam logic [3:0] FI_INIT    = 4'd1;
    localparam logic [3:0] DI_INIT    = 4'd1;
    localparam logic [7:0] WI_INIT    = 8'd10;
    localparam int         WT_PER_WI  = 960;
    localparam int         DFLT_LEN   = 4;
    localparam logic [7:0] PPS_START  = 8'hFF;

    // power-up answer-to-reset content
    function automatic logic [7:0] dflt_atr(input int idx);
        case (idx)
            0:       dflt_atr = 8'h3B;
            1:       dflt_atr = 8'h02;
            2:       dflt_atr = 8'h14;
            3:       dflt_atr = 8'h50;
            default: dflt_atr = 8'h00;
        endcase
    endfunction

endpackage

// File: rtl/card_line_tracker.sv
module card_line_tracker (
    input  logic clk,
    input  logic rst_n,
    input  logic sup_lvl,
    input  logic cclk_lvl,
    input  logic rst_lvl,
    output logic sup_rise,
    output logic cclk_rise,
    output logic rst_release
);
    logic sup_q, cclk_q, rst_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sup_q  <= 1'b0;
            cclk_q <= 1'b0;
            rst_q  <= 1'b1;
        end else begin
            sup_q  <= sup_lvl;
            cclk_q <= cclk_lvl;
            rst_q  <= rst_lvl;
        end
    end

    assign sup_rise    = sup_lvl  & ~sup_q;
    assign cclk_rise   = cclk_lvl & ~cclk_q;
    assign rst_release = rst_q    & ~rst_lvl;

endmodule

// File: rtl/card_guard_timer.sv
module card_guard_timer #(
    parameter  int GUARD_CLKS = 400,
    localparam int CW = $clog2(GUARD_CLKS + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic tick,
    output logic done
);
    logic [CW-1:0] cnt;
    localparam logic [CW-1:0] LAST = CW'(GUARD_CLKS - 1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (start) begin
            cnt <= '0;
        end else if (tick && cnt != LAST) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign done = tick && !start && (cnt == LAST);

    // R5
    guard_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> !done);

endmodule

// File: rtl/card_atr_store.sv
module card_atr_store
    import card_act_pkg::*;
#(
    parameter  int ATR_MAX = 33,
    localparam int AW = $clog2(ATR_MAX),
    localparam int LW = $clog2(ATR_MAX + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr,
    input  logic [AW-1:0] waddr,
    input  logic [7:0]    wdata,
    input  logic          commit,
    input  logic [LW-1:0] clen,
    input  logic          restart,
    input  logic          advance,
    output logic [7:0]    rd_byte,
    output logic          last,
    output logic          err
);
    logic [7:0]    mem [ATR_MAX];
    logic [LW-1:0] len;
    logic [LW-1:0] play_len;
    logic [AW-1:0] idx;
    logic          bad_len;

    localparam logic [LW-1:0] MAX_LEN = LW'(ATR_MAX);

    assign bad_len = (clen == '0) || (clen > MAX_LEN);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < ATR_MAX; i++) begin
                mem[i] <= dflt_atr(i);
            end
        end else if (wr && (int'(waddr) < ATR_MAX)) begin
            mem[waddr] <= wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            len <= LW'(DFLT_LEN);
            err <= 1'b0;
        end else begin
            err <= commit && bad_len;
            if (commit && !bad_len) begin
                len <= clen;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            play_len <= LW'(DFLT_LEN);
            idx      <= '0;
        end else if (restart) begin
            play_len <= len;
            idx      <= '0;
        end else if (advance && !last) begin
            idx <= idx + 1'b1;
        end
    end

    assign rd_byte = mem[idx];
    assign last    = (LW'(idx) == play_len - 1'b1);

    // R9
    reject_keeps_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (commit && bad_len) |=> (len == $past(len)) && err);

    // R6
    idx_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        LW'(idx) < play_len);

endmodule

// File: rtl/card_sess_params.sv
module card_sess_params
    import card_act_pkg::*;
#(
    parameter int WT_W = 18
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            reinit,
    input  logic            wr_en,
    input  logic [3:0]      fi_in,
    input  logic [3:0]      di_in,
    input  logic [7:0]      wi_in,
    output logic [3:0]      fi,
    output logic [3:0]      di,
    output logic [7:0]      wi,
    output logic [WT_W-1:0] wtime
);
    localparam logic [WT_W-1:0] WT_INIT = WT_W'(int'(WI_INIT) * WT_PER_WI);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fi    <= FI_INIT;
            di    <= DI_INIT;
            wi    <= WI_INIT;
            wtime <= WT_INIT;
        end else if (reinit) begin
            fi    <= FI_INIT;
            di    <= DI_INIT;
            wi    <= WI_INIT;
            wtime <= WT_INIT;
        end else if (wr_en) begin
            fi    <= fi_in;
            di    <= di_in;
            wi    <= wi_in;
            wtime <= WT_W'(wi_in) * WT_W'(WT_PER_WI);
        end
    end

endmodule

// File: rtl/card_activation_ctrl.sv
module card_activation_ctrl
    import card_act_pkg::*;
#(
    parameter  int ATR_MAX    = 33,
    parameter  int GUARD_CLKS = 400,
    parameter  int WT_W       = 18,
    localparam int AW = $clog2(ATR_MAX),
    localparam int LW = $clog2(ATR_MAX + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            sup_on,
    input  logic            cclk_on,
    input  logic            rst_line,
    input  logic            cclk_en,
    output logic            tx_valid,
    output logic [7:0]      tx_data,
    input  logic            tx_ready,
    output logic            tx_en,
    output logic            rx_en,
    input  logic            rx_valid,
    input  logic [7:0]      rx_data,
    output logic            rx_fwd_valid,
    output logic [7:0]      rx_fwd_data,
    input  logic            phase_done,
    input  logic            par_wr,
    input  logic [3:0]      par_fi,
    input  logic [3:0]      par_di,
    input  logic [7:0]      par_wi,
    output logic [3:0]      fi,
    output logic [3:0]      di,
    output logic [7:0]      wi,
    output logic [WT_W-1:0] wtime,
    input  logic            ld_wr,
    input  logic [AW-1:0]   ld_addr,
    input  logic [7:0]      ld_data,
    input  logic            ld_commit,
    input  logic [LW-1:0]   ld_len,
    output logic            ld_err,
    output logic [2:0]      phase
);
    phase_t st, st_nxt;
    logic   sup_rise, cclk_rise, rst_rel;
    logic   start_atr, guard_done, atr_last, atr_adv;

    card_line_tracker u_lines (
        .clk         (clk),
        .rst_n       (rst_n),
        .sup_lvl     (sup_on),
        .cclk_lvl    (cclk_on),
        .rst_lvl     (rst_line),
        .sup_rise    (sup_rise),
        .cclk_rise   (cclk_rise),
        .rst_release (rst_rel)
    );

    assign start_atr = sup_on && cclk_on && rst_rel;

    card_guard_timer #(.GUARD_CLKS(GUARD_CLKS)) u_guard (
        .clk   (clk),
        .rst_n (rst_n),
        .start (start_atr),
        .tick  (cclk_en && st == PH_GUARD),
        .done  (guard_done)
    );

    card_atr_store #(.ATR_MAX(ATR_MAX)) u_atr (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr      (ld_wr),
        .waddr   (ld_addr),
        .wdata   (ld_data),
        .commit  (ld_commit),
        .clen    (ld_len),
        .restart (start_atr),
        .advance (atr_adv),
        .rd_byte (tx_data),
        .last    (atr_last),
        .err     (ld_err)
    );

    card_sess_params #(.WT_W(WT_W)) u_par (
        .clk    (clk),
        .rst_n  (rst_n),
        .reinit (start_atr),
        .wr_en  (par_wr && st == PH_PPS && !start_atr),
        .fi_in  (par_fi),
        .di_in  (par_di),
        .wi_in  (par_wi),
        .fi     (fi),
        .di     (di),
        .wi     (wi),
        .wtime  (wtime)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= PH_NOPWR;
        else        st <= st_nxt;
    end

    // next-state logic
    always_comb begin
        st_nxt = st;
        if (!sup_on) begin
            st_nxt = PH_NOPWR;
        end else if (start_atr) begin
            st_nxt = PH_GUARD;
        end else if (sup_rise) begin
            st_nxt = PH_NOCLK;
        end else begin
            unique case (st)
                PH_NOCLK: if (cclk_rise)  st_nxt = PH_INRST;
                PH_GUARD: if (guard_done) st_nxt = PH_ATR;
                PH_ATR:   if (tx_ready && atr_last) st_nxt = PH_IDLE;
                PH_IDLE:  if (rx_valid)
                              st_nxt = (rx_data == PPS_START) ? PH_PPS : PH_CMD;
                PH_PPS,
                PH_CMD:   if (phase_done) st_nxt = PH_IDLE;
                default:  st_nxt = st;
            endcase
        end
    end

    // outputs
    always_comb begin
        tx_valid     = 1'b0;
        tx_en        = 1'b0;
        rx_en        = 1'b0;
        rx_fwd_valid = 1'b0;
        unique case (st)
            PH_GUARD: tx_en = 1'b1;
            PH_ATR: begin
                tx_en    = 1'b1;
                tx_valid = 1'b1;
            end
            PH_PPS, PH_IDLE, PH_CMD: begin
                rx_en        = 1'b1;
                rx_fwd_valid = rx_valid;
            end
            default: ;
        endcase
    end

    assign rx_fwd_data = rx_data;
    assign atr_adv     = tx_valid && tx_ready;
    assign phase       = st;

    // R2
    supply_loss_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !sup_on |=> (phase == 3'd0) && !tx_valid);

    // R7
    tx_rx_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid |-> (tx_en && !rx_en));

    // R7
    atr_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && tx_ready && atr_last && sup_on && !start_atr)
        |=> (phase == 3'd6) && rx_en && !tx_en);

    // R10
    guard_rx_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && st == PH_GUARD && sup_on && !start_atr && !guard_done)
        |=> st == PH_GUARD);

    // R12
    reinit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_atr |=> (fi == 4'd1) && (di == 4'd1) && (wi == 8'd10)
                      && (wtime == WT_W'(9600)));

    // R11
    par_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (par_wr && st != PH_PPS && !start_atr) |=> $stable(fi) && $stable(wi));

    // R3
    clk_only_noclk_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cclk_rise && st == PH_INRST && sup_on && !start_atr) |=> st == PH_INRST);

endmodule

// File: tb/card_activation_ctrl_bench.sv
`timescale 1ns/1ps
module card_activation_ctrl_bench;
    localparam int WT_W = 18;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sup_on = 0, cclk_on = 0, rst_line = 1, cclk_en = 0;
    logic tx_valid, tx_ready = 0, tx_en, rx_en;
    logic [7:0] tx_data;
    logic rx_valid = 0;
    logic [7:0] rx_data = 0;
    logic rx_fwd_valid;
    logic [7:0] rx_fwd_data;
    logic phase_done = 0, par_wr = 0;
    logic [3:0] par_fi = 0, par_di = 0;
    logic [7:0] par_wi = 0;
    logic [3:0] fi, di;
    logic [7:0] wi;
    logic [WT_W-1:0] wtime;
    logic ld_wr = 0, ld_commit = 0;
    logic [5:0] ld_addr = 0, ld_len = 0;
    logic [7:0] ld_data = 0;
    logic ld_err;
    logic [2:0] phase;

    int n_chk = 0, n_fail = 0;
    logic [7:0] exp_q[$];

    always #5 clk = ~clk;

    card_activation_ctrl u_card_activation_ctrl (
        .clk(clk), .rst_n(rst_n), .sup_on(sup_on), .cclk_on(cclk_on),
        .rst_line(rst_line), .cclk_en(cclk_en), .tx_valid(tx_valid),
        .tx_data(tx_data), .tx_ready(tx_ready), .tx_en(tx_en), .rx_en(rx_en),
        .rx_valid(rx_valid), .rx_data(rx_data), .rx_fwd_valid(rx_fwd_valid),
        .rx_fwd_data(rx_fwd_data), .phase_done(phase_done), .par_wr(par_wr),
        .par_fi(par_fi), .par_di(par_di), .par_wi(par_wi), .fi(fi), .di(di),
        .wi(wi), .wtime(wtime), .ld_wr(ld_wr), .ld_addr(ld_addr),
        .ld_data(ld_data), .ld_commit(ld_commit), .ld_len(ld_len),
        .ld_err(ld_err), .phase(phase)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk); #1;
    endtask

    task automatic look();
        @(negedge clk);
    endtask

    // scoreboard monitor: a handshake seen here completes at the next edge
    always @(negedge clk) begin
        if (rst_n && tx_valid && tx_ready) begin
            if (exp_q.size() == 0) begin
                chk(0, "R6 unexpected ATR byte", int'(tx_data), 0);
            end else begin
                logic [7:0] e;
                e = exp_q.pop_front();
                chk(tx_data == e, "R6/R8 ATR byte order", int'(tx_data), int'(e));
            end
        end
    end

    task automatic push_atr(input logic [7:0] b);
        exp_q.push_back(b);
    endtask

    // release reset and measure the guard delay; returns at the negedge of first tx_valid
    task automatic release_and_guard(input string tag);
        int n = 0;
        rst_line = 0; cclk_en = 0;
        step();
        look();
        chk(phase == 3'd3, {tag, " R4 enter guard"}, phase, 3);
        chk(tx_en && !rx_en, {tag, " R7 guard enables"}, {tx_en, rx_en}, 2);
        chk(fi == 1 && di == 1 && wi == 10 && wtime == 9600,
            {tag, " R12 reinit params"}, int'(wtime), 9600);
        @(posedge clk); #1; cclk_en = 1;
        for (int i = 0; i < 2000; i++) begin
            @(negedge clk);
            if (tx_valid) break;
            @(posedge clk);
            if (cclk_en) n++;
            #1 cclk_en = ~cclk_en;
        end
        chk(n == 400, {tag, " R5 guard enable count"}, n, 400);
        cclk_en = 0;
    endtask

    task automatic play_to_idle(input string tag);
        logic [7:0] held;
        tx_ready = 0;
        held = tx_data;
        step(); look();
        chk(tx_valid && tx_data == held, {tag, " R6 hold while not ready"}, int'(tx_data), int'(held));
        for (int i = 0; i < 400; i++) begin
            step();
            tx_ready = (i % 3 != 2);
            look();
            if (phase == 3'd6) break;
        end
        tx_ready = 0;
        chk(phase == 3'd6 && rx_en && !tx_en, {tag, " R7 idle after ATR"}, phase, 6);
        chk(exp_q.size() == 0, {tag, " R6 all ATR bytes sent"}, exp_q.size(), 0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        look();
        // R1
        chk(phase == 0 && !tx_valid && !tx_en && !rx_en && !ld_err, "R1 reset state", phase, 0);
        chk(fi == 1 && di == 1 && wi == 10 && wtime == 9600, "R1 reset params", int'(wtime), 9600);

        // R3: clock without supply does nothing
        step(); cclk_on = 1; step(); look();
        chk(phase == 0, "R3 clock in NOPWR ignored", phase, 0);
        cclk_on = 0; step();
        sup_on = 1; step(); look();
        chk(phase == 1, "R3 supply rise to NOCLK", phase, 1);
        // R4: release while clock off ignored
        rst_line = 0; step(); look();
        chk(phase == 1, "R4 release without clock ignored", phase, 1);
        rst_line = 1; step();
        cclk_on = 1; step(); look();
        chk(phase == 2, "R3 clock rise to INRST", phase, 2);
        cclk_on = 0; step(); cclk_on = 1; step(); look();
        chk(phase == 2, "R3 clock rise in INRST ignored", phase, 2);
        // R10: byte dropped before command phase
        rx_data = 8'h00; rx_valid = 1; look();
        chk(!rx_fwd_valid, "R10 no forward in INRST", rx_fwd_valid, 0);
        step(); rx_valid = 0; look();
        chk(phase == 2, "R10 phase kept in INRST", phase, 2);

        // default ATR session (R8)
        step();
        push_atr(8'h3B); push_atr(8'h02); push_atr(8'h14); push_atr(8'h50);
        release_and_guard("s1");
        play_to_idle("s1");

        // command phase
        step(); rx_data = 8'h12; rx_valid = 1; look();
        chk(rx_fwd_valid && rx_fwd_data == 8'h12, "R10 forward in IDLE", int'(rx_fwd_data), 8'h12);
        step(); rx_valid = 0; look();
        chk(phase == 7, "R10 non-FF enters CMD", phase, 7);
        step(); phase_done = 1; step(); phase_done = 0; look();
        chk(phase == 6, "R10 done returns IDLE", phase, 6);
        step(); rx_data = 8'hFF; rx_valid = 1; step(); rx_valid = 0; look();
        chk(phase == 5, "R10 FF enters PPS", phase, 5);
        step(); par_fi = 9; par_di = 3; par_wi = 20; par_wr = 1; step(); par_wr = 0; look();
        chk(fi == 9 && di == 3 && wi == 20, "R11 params written in PPS", {fi, di}, 8'h93);
        chk(wtime == 19200, "R11 wtime from wi", int'(wtime), 19200);
        step(); phase_done = 1; step(); phase_done = 0; look();
        chk(phase == 6, "R10 done leaves PPS", phase, 6);
        step(); par_fi = 2; par_wi = 7; par_wr = 1; step(); par_wr = 0; look();
        chk(fi == 9 && wi == 20, "R11 write outside PPS ignored", int'(fi), 9);

        // load a new ATR (R9)
        step();
        for (int i = 0; i < 6; i++) begin
            ld_wr = 1; ld_addr = 6'(i); ld_data = 8'hA0 + 8'(i); step();
        end
        ld_wr = 0; ld_len = 6; ld_commit = 1; step(); ld_commit = 0; look();
        chk(!ld_err, "R9 legal length accepted", ld_err, 0);
        step(); ld_len = 34; ld_commit = 1; step(); ld_commit = 0; look();
        chk(ld_err, "R9 length 34 rejected", ld_err, 1);
        step(); look();
        chk(!ld_err, "R9 error lasts one cycle", ld_err, 0);
        ld_len = 0; ld_commit = 1; step(); ld_commit = 0; look();
        chk(ld_err, "R9 length 0 rejected", ld_err, 1);

        // second session with loaded ATR, reset cycle restores params
        step(); rst_line = 1; step();
        for (int i = 0; i < 6; i++) push_atr(8'hA0 + 8'(i));
        release_and_guard("s2");
        play_to_idle("s2");

        // supply loss during ATR (R2)
        step(); rst_line = 1; step();
        for (int i = 0; i < 6; i++) push_atr(8'hA0 + 8'(i));
        release_and_guard("s3");
        step(); tx_ready = 1; step(); step(); tx_ready = 0;
        sup_on = 0; step(); look();
        chk(phase == 0 && !tx_valid && !tx_en, "R2 supply loss aborts ATR", phase, 0);
        exp_q.delete();
        step(); look();
        chk(phase == 0, "R2 stays without supply", phase, 0);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule